// File: doc/BRIEF.md
# Packed SIMD integer ALU

This block is a one-stage datapath that treats two 64-bit operands as vectors of small integers and applies one operation to every lane at once. An element-size code picks the lane width: eight 8-bit lanes, four 16-bit lanes or two 32-bit lanes. The operations are wraparound add and subtract, signed and unsigned saturating add and subtract, lane-wise equality and signed greater-than compares that produce all-ones or all-zeros masks, full-width AND, AND-NOT and OR, and a multiply-add that forms four signed 16-bit products and sums them in adjacent pairs into two 32-bit results.

A caller presents an opcode, a size code and the two operands with `in_valid` high. The result appears on `out_result` with `out_valid` high on the next cycle. The block accepts a new operation on every cycle and has no ready signal, so there is no back-pressure: a consumer must take the output in every cycle that `out_valid` is high, because the next accepted operation overwrites it. While `in_valid` is low the result register keeps its last value.

A typical use is pixel selection: a compare builds a lane mask, and AND, AND-NOT and OR with that mask merge two images without branches.

Top module: `psimd_alu`

## Requirements
- R1: Size code 0 selects 8-bit lanes, 1 selects 16-bit lanes, 2 selects 32-bit lanes; lane k occupies bits [k*W+W-1 : k*W] for lane width W. For size code 3 every lane-based operation (opcodes 0 to 7) returns zero.
- R2: Wraparound add (opcode 0) and subtract A minus B (opcode 1) give each lane its sum or difference modulo 2^W, and no carry or borrow crosses a lane boundary at any size.
- R3: Signed saturating add (opcode 2) and subtract (opcode 3) treat lanes as two's complement and clamp a result above the lane maximum to 2^(W-1)-1 and below the lane minimum to -2^(W-1).
- R4: Unsigned saturating add (opcode 4) clamps each lane to 2^W-1 on overflow, and unsigned saturating subtract (opcode 5) clamps each lane to 0 on underflow.
- R5: Equality compare (opcode 6) and signed greater-than compare A > B (opcode 7) write all ones into a lane where the condition holds and all zeros where it does not.
- R6: AND (opcode 8), AND-NOT computed as (NOT A) AND B (opcode 9) and OR (opcode 10) operate on all 64 bits regardless of the size code.
- R7: Multiply-add (opcode 11) ignores the size code, multiplies the four signed 16-bit lanes of A and B pairwise, puts product 1 plus product 0 in bits [31:0] and product 3 plus product 2 in bits [63:32], each sum wrapping modulo 2^32 (four inputs of -32768 give 0x80000000).
- R8: Opcodes 12 to 15 produce a zero result.
- R9: `out_valid` is high exactly in the cycle after a cycle with `in_valid` high; the result register loads only when `in_valid` is high and holds its value otherwise.
- R10: While `rst_n` is low, `out_valid` and `out_result` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operation present on the inputs this cycle |
| in_op | input | 4 | Opcode |
| in_size | input | 2 | Element size code |
| in_a | input | 64 | Operand A |
| in_b | input | 64 | Operand B |
| out_valid | output | 1 | Result valid, one cycle after acceptance |
| out_result | output | 64 | Registered result |

## Verification
The assertions watch on every cycle the one-cycle valid latency, the holding of the result while idle, the full-width logic operations, the zero result for undefined opcodes, the all-ones/all-zeros shape of compare lanes, and that an unsigned saturating byte add never gives a lane smaller than its A input. The numeric value of every lane under wraparound, signed and unsigned clamping, compares and the multiply-add, and the isolation of carries at lane edges, can only be shown by the bench's scenarios, which compare each result to a lane-by-lane model across random and boundary operands for every opcode and size code.

// File: rtl/psimd_pkg.sv
package psimd_pkg;

  typedef enum logic [3:0] {
    OP_ADD   = 4'd0,
    OP_SUB   = 4'd1,
    OP_ADDSS = 4'd2,
    OP_SUBSS = 4'd3,
    OP_ADDUS = 4'd4,
    OP_SUBUS = 4'd5,
    OP_CMPEQ = 4'd6,
    OP_CMPGT = 4'd7,
    OP_AND   = 4'd8,
    OP_ANDN  = 4'd9,
    OP_OR    = 4'd10,
    OP_MADD  = 4'd11
  } op_e;

  typedef enum logic [1:0] {
    SZ_BYTE  = 2'd0,
    SZ_WORD  = 2'd1,
    SZ_DWORD = 2'd2,
    SZ_RSVD  = 2'd3
  } size_e;

endpackage

// File: rtl/psimd_addsub.sv
// Lane-partitioned adder: one 8-bit slice per byte, carry chain cut at lane
// starts, saturation selected from the flags of each lane's top byte.
module psimd_addsub #(
  parameter int unsigned DATA_W = 64
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic [1:0]        size,
  input  logic              sub,
  input  logic              sat_en,
  input  logic              sat_signed,
  output logic [DATA_W-1:0] y
);
  localparam int unsigned NB = DATA_W / 8;

  logic [NB-1:0] cout;
  logic [NB-1:0] sov;
  logic [NB-1:0] uov;
  logic [NB-1:0] neg;
  logic [NB-1:0] first;
  logic [NB-1:0] top;

  for (genvar i = 0; i < NB; i++) begin : g_byte
    localparam int unsigned TOP_W = i | 1;
    localparam int unsigned TOP_D = i | 3;
    logic [7:0] ab;
    logic [7:0] bx;
    logic       cin;
    logic [8:0] wide;
    logic       l_sov;
    logic       l_uov;
    logic       l_neg;
    logic [7:0] sat_hi;
    logic [7:0] sat_lo;

    assign ab = a[i*8 +: 8];
    assign bx = b[i*8 +: 8] ^ {8{sub}};

    assign first[i] = (size == 2'd0) ||
                      (size == 2'd1 && (i % 2) == 0) ||
                      (size >= 2'd2 && (i % 4) == 0);
    assign top[i]   = (size == 2'd0) ||
                      (size == 2'd1 && (i % 2) == 1) ||
                      (size >= 2'd2 && (i % 4) == 3);

    if (i == 0) begin : g_lsb
      assign cin = first[0] & sub;
    end else begin : g_mid
      assign cin = first[i] ? sub : cout[i-1];
    end

    assign wide    = {1'b0, ab} + {1'b0, bx} + {8'd0, cin};
    assign cout[i] = wide[8];
    assign sov[i]  = (ab[7] == bx[7]) && (wide[7] != ab[7]);
    assign uov[i]  = sub ? ~wide[8] : wide[8];
    assign neg[i]  = ab[7];

    always_comb begin
      case (size)
        2'd0:    begin l_sov = sov[i];     l_uov = uov[i];     l_neg = neg[i];     end
        2'd1:    begin l_sov = sov[TOP_W]; l_uov = uov[TOP_W]; l_neg = neg[TOP_W]; end
        default: begin l_sov = sov[TOP_D]; l_uov = uov[TOP_D]; l_neg = neg[TOP_D]; end
      endcase
    end

    assign sat_hi = top[i] ? 8'h7F : 8'hFF;
    assign sat_lo = top[i] ? 8'h80 : 8'h00;

    assign y[i*8 +: 8] = !sat_en    ? wide[7:0] :
                         sat_signed ? (l_sov ? (l_neg ? sat_lo : sat_hi) : wide[7:0]) :
                                      (l_uov ? (sub ? 8'h00 : 8'hFF) : wide[7:0]);
  end

endmodule

// File: rtl/psimd_cmp.sv
// Lane compares for every size in parallel; the size code picks one.
module psimd_cmp #(
  parameter int unsigned DATA_W = 64
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic [1:0]        size,
  input  logic              gt_mode,
  output logic [DATA_W-1:0] y
);
  localparam int unsigned NSIZE = 3;

  logic [NSIZE-1:0][DATA_W-1:0] mask;

  for (genvar s = 0; s < NSIZE; s++) begin : g_size
    localparam int unsigned W = 8 << s;
    localparam int unsigned N = DATA_W / W;
    for (genvar l = 0; l < N; l++) begin : g_lane
      logic hit;
      assign hit = gt_mode ? ($signed(a[l*W +: W]) > $signed(b[l*W +: W]))
                           : (a[l*W +: W] == b[l*W +: W]);
      assign mask[s][l*W +: W] = {W{hit}};
    end
  end

  always_comb begin
    case (size)
      2'd0:    y = mask[0];
      2'd1:    y = mask[1];
      2'd2:    y = mask[2];
      default: y = '0;
    endcase
  end

endmodule

// File: rtl/psimd_madd.sv
// Signed 16x16 products summed in adjacent pairs into 32-bit lanes.
module psimd_madd #(
  parameter int unsigned DATA_W = 64
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  output logic [DATA_W-1:0] y
);
  localparam int unsigned NPAIR = DATA_W / 32;

  for (genvar p = 0; p < NPAIR; p++) begin : g_pair
    logic signed [31:0] prod_lo;
    logic signed [31:0] prod_hi;
    assign prod_lo = $signed(a[p*32 +: 16]) * $signed(b[p*32 +: 16]);
    assign prod_hi = $signed(a[p*32+16 +: 16]) * $signed(b[p*32+16 +: 16]);
    assign y[p*32 +: 32] = prod_lo + prod_hi;
  end

endmodule

// File: rtl/psimd_alu.sv
module psimd_alu #(
  parameter int unsigned DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [3:0]        in_op,
  input  logic [1:0]        in_size,
  input  logic [DATA_W-1:0] in_a,
  input  logic [DATA_W-1:0] in_b,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_result
);
  import psimd_pkg::*;

  op_e               op;
  logic              size_ok;
  logic              as_sub;
  logic              as_sat;
  logic              as_signed;
  logic [DATA_W-1:0] as_y;
  logic [DATA_W-1:0] cmp_y;
  logic [DATA_W-1:0] madd_y;
  logic [DATA_W-1:0] next_result;

  assign op        = op_e'(in_op);
  assign size_ok   = (size_e'(in_size) != SZ_RSVD);
  assign as_sub    = (op == OP_SUB) || (op == OP_SUBSS) || (op == OP_SUBUS);
  assign as_sat    = (op == OP_ADDSS) || (op == OP_SUBSS) ||
                     (op == OP_ADDUS) || (op == OP_SUBUS);
  assign as_signed = (op == OP_ADDSS) || (op == OP_SUBSS);

  psimd_addsub #(.DATA_W(DATA_W)) u_addsub (
    .a          (in_a),
    .b          (in_b),
    .size       (in_size),
    .sub        (as_sub),
    .sat_en     (as_sat),
    .sat_signed (as_signed),
    .y          (as_y)
  );

  psimd_cmp #(.DATA_W(DATA_W)) u_cmp (
    .a       (in_a),
    .b       (in_b),
    .size    (in_size),
    .gt_mode (op == OP_CMPGT),
    .y       (cmp_y)
  );

  psimd_madd #(.DATA_W(DATA_W)) u_madd (
    .a (in_a),
    .b (in_b),
    .y (madd_y)
  );

  always_comb begin
    case (op)
      OP_ADD, OP_SUB, OP_ADDSS, OP_SUBSS,
      OP_ADDUS, OP_SUBUS:  next_result = size_ok ? as_y : '0;
      OP_CMPEQ, OP_CMPGT:  next_result = cmp_y;
      OP_AND:              next_result = in_a & in_b;
      OP_ANDN:             next_result = ~in_a & in_b;
      OP_OR:               next_result = in_a | in_b;
      OP_MADD:             next_result = madd_y;
      default:             next_result = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_result <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) out_result <= next_result;
    end
  end

endmodule

// File: rtl/psimd_alu_chk.sv
module psimd_alu_chk #(
  parameter int unsigned DATA_W = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic [3:0]        in_op,
  input logic [1:0]        in_size,
  input logic [DATA_W-1:0] in_a,
  input logic [DATA_W-1:0] in_b,
  input logic              out_valid,
  input logic [DATA_W-1:0] out_result
);
  localparam int unsigned NB = DATA_W / 8;

  logic [3:0]        q_op;
  logic [1:0]        q_size;
  logic [DATA_W-1:0] q_a;
  logic [DATA_W-1:0] q_b;
  logic              mask_ok;
  logic              usat_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_op   <= '0;
      q_size <= '0;
      q_a    <= '0;
      q_b    <= '0;
    end else if (in_valid) begin
      q_op   <= in_op;
      q_size <= in_size;
      q_a    <= in_a;
      q_b    <= in_b;
    end
  end

  always_comb begin
    mask_ok = 1'b1;
    usat_ok = 1'b1;
    for (int i = 0; i < NB; i++) begin
      if (out_result[i*8 +: 8] != 8'h00 && out_result[i*8 +: 8] != 8'hFF) mask_ok = 1'b0;
      if (out_result[i*8 +: 8] < q_a[i*8 +: 8]) usat_ok = 1'b0;
    end
  end

  // R9
  p_latency_r9: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  p_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(out_result));
  // R10
  p_reset_r10: assert property (@(posedge clk)
    !rst_n |-> (!out_valid && out_result == '0));
  // R6
  p_and_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && q_op == 4'd8) |-> out_result == (q_a & q_b));
  p_andn_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && q_op == 4'd9) |-> out_result == (~q_a & q_b));
  p_or_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && q_op == 4'd10) |-> out_result == (q_a | q_b));
  // R8
  p_unknown_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && q_op > 4'd11) |-> out_result == '0);
  // R5
  p_mask_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && (q_op == 4'd6 || q_op == 4'd7)) |-> mask_ok);
  // R4
  p_usat_floor_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && q_op == 4'd4 && q_size == 2'd0) |-> usat_ok);

endmodule

bind psimd_alu psimd_alu_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/psimd_alu_bench.sv
module psimd_alu_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [3:0]  in_op = '0;
  logic [1:0]  in_size = '0;
  logic [63:0] in_a = '0;
  logic [63:0] in_b = '0;
  logic        out_valid;
  logic [63:0] out_result;

  int n_checks = 0;
  int n_fails  = 0;
  logic [63:0] last_exp = '0;

  always #5 clk = ~clk;

  psimd_alu u_psimd_alu (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
    .in_size(in_size), .in_a(in_a), .in_b(in_b),
    .out_valid(out_valid), .out_result(out_result)
  );

  function automatic string req_of(int op);
    case (op)
      0, 1:    return "R2";
      2, 3:    return "R3";
      4, 5:    return "R4";
      6, 7:    return "R5";
      8, 9, 10: return "R6";
      11:      return "R7";
      default: return "R8";
    endcase
  endfunction

  function automatic logic [63:0] model(int op, int sz, logic [63:0] a, logic [63:0] b);
    logic [63:0] r = '0;
    logic [63:0] vv;
    longint w, umax, hi, lo, ea, eb, sa, sb, v, s;
    if (op == 8)  return a & b;
    if (op == 9)  return ~a & b;
    if (op == 10) return a | b;
    if (op == 11) begin
      for (int p = 0; p < 2; p++) begin
        s = 0;
        for (int k = 0; k < 2; k++)
          s += longint'($signed(a[(2*p+k)*16 +: 16])) * longint'($signed(b[(2*p+k)*16 +: 16]));
        vv = s;
        r[p*32 +: 32] = vv[31:0];
      end
      return r;
    end
    if (op > 11 || sz == 3) return '0;   // R8, R1
    w    = 8 << sz;
    umax = (longint'(1) << w) - 1;
    hi   = (longint'(1) << (w - 1)) - 1;
    lo   = -(longint'(1) << (w - 1));
    for (int l = 0; l < 64 / w; l++) begin
      ea = longint'(a >> (l * w)) & umax;
      eb = longint'(b >> (l * w)) & umax;
      sa = (ea > hi) ? ea - umax - 1 : ea;
      sb = (eb > hi) ? eb - umax - 1 : eb;
      case (op)
        0: v = ea + eb;
        1: v = ea - eb;
        2: begin v = sa + sb; if (v > hi) v = hi; if (v < lo) v = lo; end
        3: begin v = sa - sb; if (v > hi) v = hi; if (v < lo) v = lo; end
        4: begin v = ea + eb; if (v > umax) v = umax; end
        5: begin v = ea - eb; if (v < 0) v = 0; end
        6: v = (ea == eb) ? umax : 0;
        default: v = (sa > sb) ? umax : 0;
      endcase
      vv = v;
      vv = vv & umax;
      r = r | (vv << (l * w));
    end
    return r;
  endfunction

  function automatic logic [63:0] corner_operand();
    logic [63:0] v;
    for (int i = 0; i < 8; i++) begin
      case ($urandom_range(0, 7))
        0: v[i*8 +: 8] = 8'h00;
        1: v[i*8 +: 8] = 8'h7F;
        2: v[i*8 +: 8] = 8'h80;
        3: v[i*8 +: 8] = 8'hFF;
        4: v[i*8 +: 8] = 8'h01;
        default: v[i*8 +: 8] = 8'($urandom());
      endcase
    end
    return v;
  endfunction

  task automatic check(string req, logic [63:0] got, logic [63:0] exp, string what);
    n_checks++;
    if (got !== exp) begin
      n_fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, got, exp);
    end
  endtask

  // Drives one operation (caller is at a falling edge), waits to the next
  // falling edge and compares the registered result.
  task automatic issue(int op, int sz, logic [63:0] a, logic [63:0] b, logic [63:0] exp, string tag);
    in_valid = 1'b1;
    in_op    = 4'(op);
    in_size  = 2'(sz);
    in_a     = a;
    in_b     = b;
    @(negedge clk);
    check("R9", {63'd0, out_valid}, 64'd1, "out_valid after accept");
    check(tag, out_result, exp, $sformatf("op %0d size %0d", op, sz));
    last_exp = exp;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  endtask

  initial begin
    #2_000_000;
    n_checks++;
    n_fails++;
    $display("FAIL R9 watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [63:0] a, b;
    int op, sz;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R10: reset state
    check("R10", {63'd0, out_valid}, 64'd0, "out_valid in reset");
    check("R10", out_result, 64'd0, "result in reset");
    rst_n = 1'b1;
    @(negedge clk);

    // R3 signed byte clamps: 7F+01 -> 7F, 80+FF -> 80
    issue(2, 0, 64'h7F7F_7F7F_807F_8080, 64'h0101_0101_FF01_FFFF, 64'h7F7F_7F7F_807F_8080, "R3");
    // R3 signed word subtract: 8000-0001 -> 8000, 7FFF-FFFF -> 7FFF
    issue(3, 1, 64'h8000_7FFF_0005_0000, 64'h0001_FFFF_0003_0001, 64'h8000_7FFF_0002_FFFF, "R3");
    // R4 unsigned byte clamps
    issue(4, 0, 64'hFF80_0000_0000_00FF, 64'h0180_0000_0000_0001, 64'hFFFF_0000_0000_00FF, "R4");
    issue(5, 0, 64'h0000_0000_0000_1000, 64'h0000_0000_0000_0101, 64'h0000_0000_0000_0F00, "R4");
    // R2 no carry across byte lanes, but across bytes inside a word
    issue(0, 0, 64'h00FF_00FF_00FF_00FF, 64'h0001_0001_0001_0001, 64'h0000_0000_0000_0000, "R2");
    issue(0, 1, 64'h00FF_00FF_FFFF_0000, 64'h0001_0001_0001_0000, 64'h0100_0100_0000_0000, "R2");
    issue(1, 2, 64'h0000_0000_0000_0000, 64'h0000_0000_0000_0001, 64'h0000_0000_FFFF_FFFF, "R2");
    // R5 compares
    issue(7, 1, 64'h0005_8000_0001_7FFF, 64'h0003_0001_0001_8000, 64'hFFFF_0000_0000_FFFF, "R5");
    issue(6, 0, 64'h1122_3344_5566_7788, 64'h1100_3300_5500_7700, 64'hFF00_FF00_FF00_FF00, "R5");
    // R7 multiply-add including the single wrap case
    issue(11, 0, 64'h8000_8000_0002_0003, 64'h8000_8000_0004_FFFF, 64'h8000_0000_0000_0005, "R7");
    // R6 logic ops ignore size code 3
    issue(9, 3, 64'hF0F0_F0F0_0000_FFFF, 64'hFFFF_0000_FFFF_FFFF, 64'h0F0F_0000_FFFF_0000, "R6");
    // R1 reserved size on a lane op; R8 unknown opcodes
    issue(0, 3, 64'h1111_1111_1111_1111, 64'h2222_2222_2222_2222, 64'd0, "R1");
    issue(12, 0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h1, 64'd0, "R8");
    issue(15, 2, 64'h1234_5678_9ABC_DEF0, 64'h1, 64'd0, "R8");

    // R9: idle input with new data leaves result and valid alone
    in_valid = 1'b0;
    in_op    = 4'd10;
    in_a     = 64'hDEAD_BEEF_DEAD_BEEF;
    @(negedge clk);
    check("R9", {63'd0, out_valid}, 64'd0, "out_valid when idle");
    check("R9", out_result, last_exp, "result held when idle");

    // Constrained random sweep over all opcodes and sizes (R1-related checks per op)
    for (int t = 0; t < 3000; t++) begin
      op = $urandom_range(0, 15);
      if (op > 11 && $urandom_range(0, 3) != 0) op = $urandom_range(0, 11);
      sz = ($urandom_range(0, 19) == 0) ? 3 : $urandom_range(0, 2);
      a  = ($urandom_range(0, 1) != 0) ? corner_operand() : {$urandom(), $urandom()};
      b  = ($urandom_range(0, 1) != 0) ? corner_operand() : {$urandom(), $urandom()};
      if (sz == 3 && op < 8) issue(op, sz, a, b, model(op, sz, a, b), "R1");
      else                   issue(op, sz, a, b, model(op, sz, a, b), req_of(op));
      if ($urandom_range(0, 15) == 0) begin
        in_valid = 1'b0;
        @(negedge clk);
        check("R9", {63'd0, out_valid}, 64'd0, "bubble valid");
        check("R9", out_result, last_exp, "bubble hold");
      end
    end
    in_valid = 1'b0;
    @(negedge clk);
    finish_run();
  end

endmodule